// File: doc/BRIEF.md
# Fractional baud rate generator

This block sets the bit timing of a serial channel that runs either as an asynchronous receiver/transmitter or as a synchronous shifter. Four clock-enable strobes come from a shared timer prescaler, and a 2-bit select chooses one of them. The chosen strobe feeds a divider. The divider either counts a whole number N of strobes, or, in asynchronous mode only, divides by N + (16 − K)/16. It does the fractional divide by making some output periods one strobe longer than others. The divider emits `div_tick`. A post-divider then produces `bit_tick`, which marks one bit time. It divides `div_tick` by 16 in asynchronous mode and by 2 in synchronous mode.

Both outputs are single-cycle enables in the system clock domain. The divide, fraction and mode settings are plain inputs. The block reads them only when the divider reloads at the end of a period. A controller can therefore change them at any moment, and the period in progress is never cut short or stretched by the change.

Top module: `frac_baud_gen`

## Requirements
- R1: Only pulses on `tick_in[clk_sel]` advance the divider. The other three strobe inputs have no effect on the output timing.
- R2: When `frac_en` is 0, each divider period lasts exactly N selected strobes. N equals `div_n`, except that the value 0 encodes N = 16. `frac_k` has no effect in this case.
- R3: When `frac_en` is 1, `uart_mode` is 1 and N is 2 to 15, every period lasts N or N+1 strobes. Any 16 consecutive periods last 16·N + (16 − K) strobes in total, with K = `frac_k` in the range 1 to 15.
- R4: When N is 1 or 16, `frac_en` is treated as 0.
- R5: When `uart_mode` is 0, `frac_en` is treated as 0.
- R6: In asynchronous mode (`uart_mode` = 1), `bit_tick` rises on every 16th `div_tick`, in the same cycle as that `div_tick`.
- R7: In synchronous mode (`uart_mode` = 0), `bit_tick` rises on every 2nd `div_tick`, in the same cycle as that `div_tick`.
- R8: While `rst` is high, both outputs are 0. After `rst` falls, the first `div_tick` follows N selected strobes, and the first `bit_tick` coincides with the 16th `div_tick` in asynchronous mode.
- R9: A change to `div_n`, `frac_k`, `frac_en` or `uart_mode` does not alter the period in progress. It takes effect from the next period on.
- R10: Each output is a pulse one clock cycle wide. `div_tick` is high in the cycle after the strobe that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 4 | Prescaler clock-enable strobes |
| clk_sel | input | 2 | Selects which strobe feeds the divider |
| div_n | input | 4 | Integer divisor N (0 means 16) |
| frac_k | input | 4 | Fraction value K |
| frac_en | input | 1 | Enables the N + (16−K)/16 divide |
| uart_mode | input | 1 | 1 = asynchronous (÷16 bit rate), 0 = synchronous (÷2) |
| div_tick | output | 1 | Divider output pulse |
| bit_tick | output | 1 | Bit-rate pulse |

## Verification
The assertions check four things on every cycle. A `div_tick` always follows a strobe on the selected input. A cycle without that strobe leaves the counter unchanged. Every `bit_tick` coincides with a `div_tick`. In synchronous mode, a reload always loads a whole-N period. Other behaviour only shows over many cycles, so only the bench scenarios can demonstrate it. This covers the exact 16-period totals for every legal N/K pair, the 16 and 2 spacing of `bit_tick`, the ignored settings, and the moment a changed setting first takes effect.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int N_W      = 4,
  parameter int SEL_W    = 2,
  parameter int UART_OVS = 16,
  parameter int SIO_OVS  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [(1<<SEL_W)-1:0] tick_in,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [N_W-1:0]     div_n,
  input  logic [N_W-1:0]     frac_k,
  input  logic               frac_en,
  input  logic               uart_mode,
  output logic               div_tick,
  output logic               bit_tick
);
  localparam int LW    = N_W + 1;
  localparam int STEPS = 1 << N_W;
  localparam int PCW   = $clog2(UART_OVS > SIO_OVS ? UART_OVS : SIO_OVS);

  logic           sel_tick, last, reload, frac_ok, stretch, cur_uart;
  logic [LW-1:0]  n_eff, inc, sum, next_len, cur_len, cnt;
  logic [N_W-1:0] acc;
  logic [PCW-1:0] pcnt, lim;

  assign sel_tick = tick_in[clk_sel];
  assign n_eff    = (div_n == '0) ? LW'(STEPS) : {1'b0, div_n};
  assign frac_ok  = frac_en && uart_mode && (div_n > N_W'(1));
  assign inc      = LW'(STEPS) - {1'b0, frac_k};
  assign sum      = {1'b0, acc} + inc;
  assign stretch  = frac_ok && sum[N_W];
  assign next_len = n_eff + LW'(stretch);
  assign last     = (cnt == cur_len - LW'(1));
  assign reload   = sel_tick && last;
  assign lim      = cur_uart ? PCW'(UART_OVS - 1) : PCW'(SIO_OVS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      cur_len  <= n_eff;
      cur_uart <= uart_mode;
      pcnt     <= '0;
      div_tick <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      div_tick <= reload;
      bit_tick <= reload && (pcnt >= lim);
      if (reload) begin
        cnt      <= '0;
        cur_len  <= next_len;
        acc      <= frac_ok ? sum[N_W-1:0] : '0;
        cur_uart <= uart_mode;
        pcnt     <= (pcnt >= lim) ? '0 : pcnt + PCW'(1);
      end else if (sel_tick) begin
        cnt <= cnt + LW'(1);
      end
    end
  end
endmodule

module frac_baud_gen_chk #(
  parameter int N_W   = 4,
  parameter int SEL_W = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [(1<<SEL_W)-1:0] tick_in,
  input logic [SEL_W-1:0]      clk_sel,
  input logic                  uart_mode,
  input logic                  reload,
  input logic [N_W:0]          n_eff,
  input logic [N_W:0]          cur_len,
  input logic [N_W:0]          cnt,
  input logic                  div_tick,
  input logic                  bit_tick
);
  AST_DIV_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> $past(tick_in[clk_sel])); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_in[clk_sel] |=> ($stable(cnt) && !div_tick)); // R1
  AST_BIT_WITH_DIV: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> div_tick); // R6
  AST_SIO_WHOLE_N: assert property (@(posedge clk) disable iff (rst)
    ($past(reload) && !$past(uart_mode)) |-> (cur_len == $past(n_eff))); // R5
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.N_W(N_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .tick_in(tick_in), .clk_sel(clk_sel),
  .uart_mode(uart_mode), .reload(reload), .n_eff(n_eff), .cur_len(cur_len),
  .cnt(cnt), .div_tick(div_tick), .bit_tick(bit_tick)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tick_in = 4'hF;
  logic [1:0] clk_sel = 2'd0;
  logic [3:0] div_n = 4'd4;
  logic [3:0] frac_k = 4'd0;
  logic       frac_en = 1'b0;
  logic       uart_mode = 1'b1;
  logic       div_tick, bit_tick;

  int total = 0, bad = 0, cyc = 0;
  bit slow = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst(rst), .tick_in(tick_in), .clk_sel(clk_sel),
    .div_n(div_n), .frac_k(frac_k), .frac_en(frac_en), .uart_mode(uart_mode),
    .div_tick(div_tick), .bit_tick(bit_tick)
  );

  // strobe driver: fast = all strobes every cycle; slow = selected strobe every 3rd cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (slow)
      tick_in = (4'hF & ~(4'd1 << clk_sel)) | (((cyc % 3) == 0) ? (4'd1 << clk_sel) : 4'd0);
    else
      tick_in = 4'hF;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_div();
    do @(negedge clk); while (!div_tick);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n = n + 1; end while (!div_tick);
  endtask

  task automatic measure16(output int sum);
    int n;
    wait_div();
    sum = 0;
    for (int i = 0; i < 16; i++) begin interval(n); sum = sum + n; end
  endtask

  task automatic bit_spacing(output int n);
    do @(negedge clk); while (!bit_tick);
    n = 0;
    do begin wait_div(); n = n + 1; end while (!bit_tick);
  endtask

  // columns: sel, n, k, frac_en, uart, slow, expected cycles over 16 periods
  localparam int NV = 10;
  localparam int VEC [NV][7] = '{
    '{0,  4,  0, 0, 1, 0,  64},
    '{1,  0,  5, 0, 1, 0, 256},
    '{2,  1,  3, 1, 1, 0,  16},
    '{3,  0,  3, 1, 1, 0, 256},
    '{0,  5,  4, 1, 0, 0,  80},
    '{1,  5,  4, 1, 1, 0,  92},
    '{2,  4,  0, 0, 1, 1, 192},
    '{3,  7,  0, 0, 0, 1, 336},
    '{0,  2, 15, 1, 1, 1,  99},
    '{1, 15,  1, 1, 1, 0, 255}
  };

  initial begin
    int m, n, nd;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 div_tick in reset", int'(div_tick), 0);
    chk("R8 bit_tick in reset", int'(bit_tick), 0);
    div_n = 4'd5; uart_mode = 1'b1; frac_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    interval(n);
    chk("R8 first div after reset", n, 5);
    nd = 1;
    while (!bit_tick) begin wait_div(); nd = nd + 1; end
    chk("R8 first bit_tick after reset", nd, 16);

    // table: R1 select, R2 integer, R4, R5, R3 fractional
    for (int v = 0; v < NV; v++) begin
      clk_sel = VEC[v][0]; div_n = VEC[v][1]; frac_k = VEC[v][2];
      frac_en = VEC[v][3]; uart_mode = VEC[v][4]; slow = VEC[v][5];
      measure16(m);
      chk($sformatf("R1/R2/R3/R4/R5 vec%0d", v), m, VEC[v][6]);
    end
    slow = 1'b0; clk_sel = 2'd0;

    // R2: every integer N, K ignored
    for (int nn = 0; nn < 16; nn++) begin
      div_n = nn; frac_k = 4'd7; frac_en = 1'b0; uart_mode = 1'b1;
      measure16(m);
      chk($sformatf("R2 N=%0d", nn == 0 ? 16 : nn), m, 16 * (nn == 0 ? 16 : nn));
    end

    // R3: every legal N/K pair
    for (int nn = 2; nn <= 15; nn++)
      for (int kk = 1; kk <= 15; kk++) begin
        div_n = nn; frac_k = kk; frac_en = 1'b1; uart_mode = 1'b1;
        measure16(m);
        chk($sformatf("R3 N=%0d K=%0d", nn, kk), m, 16 * nn + 16 - kk);
      end

    // R3: each period is N or N+1
    div_n = 4'd6; frac_k = 4'd9; frac_en = 1'b1; uart_mode = 1'b1;
    wait_div(); wait_div();
    for (int i = 0; i < 16; i++) begin
      interval(n);
      chk("R3 period N or N+1", int'(n == 6 || n == 7), 1);
    end

    // R6 / R7 bit spacing
    div_n = 4'd2; frac_en = 1'b0; uart_mode = 1'b1;
    bit_spacing(nd); bit_spacing(nd);
    chk("R6 div per bit (uart)", nd, 16);
    uart_mode = 1'b0;
    bit_spacing(nd); bit_spacing(nd);
    chk("R7 div per bit (sio)", nd, 2);

    // R10: pulses one cycle wide
    div_n = 4'd4; uart_mode = 1'b0;
    bit_spacing(nd);
    @(negedge clk);
    chk("R10 div_tick width", int'(div_tick), 0);
    chk("R10 bit_tick width", int'(bit_tick), 0);

    // R9: change mid-period
    div_n = 4'd8; uart_mode = 1'b1;
    wait_div(); wait_div();
    repeat (2) @(negedge clk);
    div_n = 4'd3;
    n = 2;
    do begin @(negedge clk); n = n + 1; end while (!div_tick);
    chk("R9 current period kept", n, 8);
    interval(n);
    chk("R9 new N after reload", n, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule